// File: doc/BRIEF.md
# Interrupt Entry and Return Stack Sequencer

This block carries out the memory traffic of two processor instructions: a software interrupt and an interrupt return. It owns the stack pointer, the program counter and the flag register of a 16-bit core. It reaches memory as a classic single-transfer Wishbone master with a 16-bit data bus. A one-clock start strobe selects the operation. A one-clock done pulse reports that the operation has finished.

An interrupt saves two words on a stack that grows towards lower addresses: the flag register first, widened with zeros, and then the program counter. The program counter is then loaded with the entry address, which is the 4-bit vector times eight. A return reads the two words back in the opposite order, the program counter first and then the flags. Each bus transfer waits for as many clocks as the slave needs. Transfers are separated by one clock with the strobe low, so an acknowledge that a slave leaves asserted too long cannot close the next transfer.

Top module: `irq_stack_seq`

## Requirements
- R1: While the synchronised reset is active (rst_i high for at least three clocks), sp_o, pc_o and flags_o take the parameter values SP_RST (0x0100), PC_RST (0x0040) and FLG_RST (0x5A), and stb_o, cyc_o, we_o and done_o are low.
- R2: On start_int_i, two write transfers follow. The first writes the zero-extended flags to address SP-2. The second writes PC to address SP-4. SP ends at SP-4.
- R3: After the second write is acknowledged, PC holds vector_i (latched at start) shifted left by 3, and done_o goes high for exactly one clock.
- R4: On start_ret_i, two read transfers follow. The first reads address SP into PC. The second reads address SP+2, and its low FLG_W bits go into the flags. SP ends at SP+4, and done_o pulses once.
- R5: In every transfer, stb_o, cyc_o and both sel_o bits are high together. we_o and dat_oe_o are 1 for writes and 0 for reads, and dat_o carries the pushed word during writes.
- R6: A transfer keeps stb_o high, with adr_o and we_o unchanged, until ack_i is sampled high at a rising edge. A slave inserting N wait clocks gives a strobe that is high for N+2 clocks.
- R7: stb_o is low for at least one clock after every acknowledged transfer. An ack_i that stays high only while stb_o is low does not shorten the following transfer.
- R8: ack_i is used without a synchroniser, so a slave that acknowledges one clock after seeing the strobe completes each transfer with stb_o high for exactly 2 clocks.
- R9: A start strobe that arrives while a sequence is running is ignored. Only the two transfers of the running sequence occur, and the register values reflect that sequence alone.
- R10: If start_int_i and start_ret_i are high in the same clock, the interrupt sequence is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Reset request, active high, synchronised inside |
| start_int_i | input | 1 | Start interrupt entry (one clock) |
| start_ret_i | input | 1 | Start interrupt return (one clock) |
| vector_i | input | 4 | Interrupt vector number |
| adr_o | output | 16 | Bus byte address |
| dat_o | output | 16 | Bus write data |
| dat_oe_o | output | 1 | Write data driver enable |
| dat_i | input | 16 | Bus read data |
| sel_o | output | 2 | Byte lane selects |
| stb_o | output | 1 | Transfer strobe |
| cyc_o | output | 1 | Bus cycle active |
| we_o | output | 1 | Write enable |
| ack_i | input | 1 | Slave acknowledge |
| done_o | output | 1 | One-clock completion pulse |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| flags_o | output | 8 | Flag register |

## Verification
Two things can happen in the same clock: a start strobe can arrive while a sequence is running, and both start strobes can arrive together. The first case is provoked by pulsing start_ret_i while an interrupt write is waiting on a slow slave. The check is that the log holds exactly two writes and that SP and PC match the interrupt alone. The second case is judged by seeing write transfers and the vector entry address. The leftover-acknowledge case uses a slave mode that holds ack_i high one extra clock. The check is that the next strobe still lasts the full N+2 clocks.

// File: rtl/irs_pkg.sv
package irs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    typedef enum logic {
        OP_PUSH = 1'b0,
        OP_POP  = 1'b1
    } stk_op_e;
endpackage

// File: rtl/irs_rst_sync.sv
module irs_rst_sync (
    input  logic clk_i,
    input  logic rst_i,
    output logic rst_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i) begin
        meta_q <= rst_i;
        sync_q <= meta_q;
    end

    assign rst_o = sync_q;
endmodule

// File: rtl/irs_stack_step.sv
module irs_stack_step
    import irs_pkg::*;
#(
    parameter int AW = 16
) (
    input  stk_op_e         op_i,
    input  logic [AW-1:0]   sp_i,
    output logic [AW-1:0]   adr_o,
    output logic [AW-1:0]   sp_o
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(2);

    // pre-decrement on push, post-increment on pop
    always_comb begin
        if (op_i == OP_PUSH) begin
            sp_o  = sp_i - WORD_BYTES;
            adr_o = sp_i - WORD_BYTES;
        end else begin
            sp_o  = sp_i + WORD_BYTES;
            adr_o = sp_i;
        end
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irs_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              DW        = 16,
    parameter int              FLG_W     = 8,
    parameter int              VEC_W     = 4,
    parameter int              VEC_SHIFT = 3,
    parameter logic [AW-1:0]   SP_RST    = 16'h0100,
    parameter logic [AW-1:0]   PC_RST    = 16'h0040,
    parameter logic [FLG_W-1:0] FLG_RST  = 8'h5A
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_int_i,
    input  logic              start_ret_i,
    input  logic [VEC_W-1:0]  vector_i,
    output logic [AW-1:0]     adr_o,
    output logic [DW-1:0]     dat_o,
    output logic              dat_oe_o,
    input  logic [DW-1:0]     dat_i,
    output logic [DW/8-1:0]   sel_o,
    output logic              stb_o,
    output logic              cyc_o,
    output logic              we_o,
    input  logic              ack_i,
    output logic              done_o,
    output logic [AW-1:0]     sp_o,
    output logic [AW-1:0]     pc_o,
    output logic [FLG_W-1:0]  flags_o
);
    localparam int SEL_W = DW / 8;

    typedef struct packed {
        seq_st_e           st;
        stk_op_e           op;
        logic              word;
        logic [VEC_W-1:0]  vec;
        logic [AW-1:0]     sp;
        logic [AW-1:0]     pc;
        logic [FLG_W-1:0]  flags;
        logic [AW-1:0]     adr;
        logic [DW-1:0]     wdat;
        logic              stb;
        logic              done;
    } seq_t;

    seq_t    r_d, r_q;
    logic    rst_s;
    stk_op_e step_op;
    logic [AW-1:0] step_adr, step_sp;

    irs_rst_sync i_rst_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .rst_o (rst_s)
    );

    // in idle the pending request picks the direction, afterwards the latched op
    always_comb begin
        if (r_q.st == ST_IDLE) begin
            step_op = start_int_i ? OP_PUSH : OP_POP;
        end else begin
            step_op = r_q.op;
        end
    end

    irs_stack_step #(.AW(AW)) i_stack_step (
        .op_i  (step_op),
        .sp_i  (r_q.sp),
        .adr_o (step_adr),
        .sp_o  (step_sp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_int_i || start_ret_i) begin
                    r_d.op   = step_op;
                    r_d.vec  = vector_i;
                    r_d.word = 1'b0;
                    r_d.sp   = step_sp;
                    r_d.adr  = step_adr;
                    r_d.wdat = DW'(r_q.flags);
                    r_d.stb  = 1'b1;
                    r_d.st   = ST_BUS;
                end
            end
            ST_BUS: begin
                if (ack_i) begin
                    r_d.stb = 1'b0;
                    if (r_q.op == OP_POP) begin
                        if (!r_q.word) begin
                            r_d.pc = AW'(dat_i);
                        end else begin
                            r_d.flags = dat_i[FLG_W-1:0];
                        end
                    end
                    if (!r_q.word) begin
                        r_d.st = ST_GAP;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        if (r_q.op == OP_PUSH) begin
                            r_d.pc = AW'(r_q.vec) << VEC_SHIFT;
                        end
                    end
                end
            end
            ST_GAP: begin
                r_d.word = 1'b1;
                r_d.sp   = step_sp;
                r_d.adr  = step_adr;
                r_d.wdat = DW'(r_q.pc);
                r_d.stb  = 1'b1;
                r_d.st   = ST_BUS;
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.stb = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_s) begin
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_PUSH;
            r_q.word  <= 1'b0;
            r_q.vec   <= '0;
            r_q.sp    <= SP_RST;
            r_q.pc    <= PC_RST;
            r_q.flags <= FLG_RST;
            r_q.adr   <= '0;
            r_q.wdat  <= '0;
            r_q.stb   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign adr_o    = r_q.adr;
    assign stb_o    = r_q.stb;
    assign cyc_o    = r_q.stb;
    assign sel_o    = {SEL_W{r_q.stb}};
    assign we_o     = r_q.stb && (r_q.op == OP_PUSH);
    assign dat_oe_o = r_q.stb && (r_q.op == OP_PUSH);
    assign dat_o    = dat_oe_o ? r_q.wdat : '0;
    assign done_o   = r_q.done;
    assign sp_o     = r_q.sp;
    assign pc_o     = r_q.pc;
    assign flags_o  = r_q.flags;

    // R2: a write transfer opens at the already lowered stack pointer
    a_r2_push_addr: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        $rose(stb_o) && we_o |-> adr_o == sp_o);

    // R4: a read transfer opens at the stack pointer before its increment
    a_r4_pop_addr: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        $rose(stb_o) && !we_o |-> adr_o == sp_o - AW'(2));

    // R6: an unacknowledged transfer holds its strobe, address and direction
    a_r6_hold: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        stb_o && !ack_i |=> stb_o && $stable(adr_o) && $stable(we_o));

    // R7: an acknowledged transfer is followed by a clock with the strobe low
    a_r7_gap: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        stb_o && ack_i |=> !stb_o);

    // R3: the done pulse lasts one clock and comes with the bus idle
    a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        done_o |-> !stb_o ##1 !done_o);

    // R3: an interrupt ends with the entry address in PC
    a_r3_entry_pc: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        stb_o && we_o && ack_i && $past(stb_o) |=> !done_o || pc_o[VEC_SHIFT-1:0] == '0);
endmodule

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        start_int_i = 1'b0;
    logic        start_ret_i = 1'b0;
    logic [3:0]  vector_i = '0;
    logic [15:0] adr_o, dat_o, dat_i, sp_o, pc_o;
    logic        dat_oe_o, stb_o, cyc_o, we_o, ack_i, done_o;
    logic [1:0]  sel_o;
    logic [7:0]  flags_o;

    irq_stack_seq i_irq_stack_seq (
        .clk_i(clk_i), .rst_i(rst_i), .start_int_i(start_int_i),
        .start_ret_i(start_ret_i), .vector_i(vector_i), .adr_o(adr_o),
        .dat_o(dat_o), .dat_oe_o(dat_oe_o), .dat_i(dat_i), .sel_o(sel_o),
        .stb_o(stb_o), .cyc_o(cyc_o), .we_o(we_o), .ack_i(ack_i),
        .done_o(done_o), .sp_o(sp_o), .pc_o(pc_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // slave model and transfer log
    logic [15:0] mem [0:127];
    int          wait_n = 0;
    bit          hold_mode = 1'b0;
    logic        ack_slv = 1'b0;
    logic        stale_q = 1'b0;
    int          cnt = 0;
    int          len = 0;
    int          lcnt = 0;
    logic [15:0] log_adr [0:63];
    logic [15:0] log_dat [0:63];
    logic        log_we  [0:63];
    int          log_len [0:63];
    logic        log_sel_ok [0:63];

    assign ack_i = ack_slv;
    assign dat_i = mem[adr_o[7:1]];

    always @(posedge clk_i) begin
        if (stb_o && ack_i) begin
            log_adr[lcnt % 64]    <= adr_o;
            log_we[lcnt % 64]     <= we_o;
            log_dat[lcnt % 64]    <= we_o ? dat_o : dat_i;
            log_len[lcnt % 64]    <= len + 1;
            log_sel_ok[lcnt % 64] <= cyc_o && (sel_o == 2'b11) && (dat_oe_o == we_o);
            lcnt <= lcnt + 1;
            len  <= 0;
        end else if (stb_o) begin
            len <= len + 1;
        end
        if (ack_slv) begin
            ack_slv <= hold_mode && !stale_q;
            stale_q <= hold_mode && !stale_q;
            cnt     <= 0;
        end else if (stb_o) begin
            if (cnt == wait_n) begin
                ack_slv <= 1'b1;
                if (we_o) mem[adr_o[7:1]] <= dat_o;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    logic [15:0] sp_m, pc_m;
    logic [7:0]  fl_m;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit do_int, input bit do_ret, input logic [3:0] vec);
        @(negedge clk_i);
        start_int_i = do_int;
        start_ret_i = do_ret;
        vector_i    = vec;
        @(negedge clk_i);
        start_int_i = 1'b0;
        start_ret_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk_i);
        end
        chk(seen, tag, 32'(seen), 32'd1);
        @(negedge clk_i);
        chk(!done_o, tag, 32'(done_o), 32'd0);
    endtask

    task automatic check_push_pair(input int base, input int lenx, input string tag);
        chk(lcnt - base == 2, {tag, " count"}, 32'(lcnt - base), 32'd2);
        chk(log_adr[base % 64] == sp_m - 16'd2 && log_we[base % 64], {tag, " R2 first adr"},
            32'(log_adr[base % 64]), 32'(sp_m - 16'd2));
        chk(log_dat[base % 64] == {8'h00, fl_m}, {tag, " R2 flags data"},
            32'(log_dat[base % 64]), 32'({8'h00, fl_m}));
        chk(log_adr[(base+1) % 64] == sp_m - 16'd4 && log_we[(base+1) % 64], {tag, " R2 second adr"},
            32'(log_adr[(base+1) % 64]), 32'(sp_m - 16'd4));
        chk(log_dat[(base+1) % 64] == pc_m, {tag, " R2 pc data"},
            32'(log_dat[(base+1) % 64]), 32'(pc_m));
        chk(log_sel_ok[base % 64] && log_sel_ok[(base+1) % 64], {tag, " R5 bus signals"},
            32'(log_sel_ok[base % 64]), 32'd1);
        chk(log_len[base % 64] == lenx && log_len[(base+1) % 64] == lenx, {tag, " R6 R7 strobe length"},
            32'(log_len[(base+1) % 64]), 32'(lenx));
    endtask

    task automatic t_reset();
        rst_i = 1'b1;
        repeat (6) @(negedge clk_i);
        chk(sp_o == 16'h0100 && pc_o == 16'h0040, "R1 sp/pc reset", {sp_o, pc_o}, 32'h01000040);
        chk(flags_o == 8'h5A, "R1 flags reset", 32'(flags_o), 32'h5A);
        chk(!stb_o && !cyc_o && !we_o && !done_o, "R1 bus idle", 32'({stb_o, cyc_o, we_o, done_o}), 32'd0);
        rst_i = 1'b0;
        repeat (4) @(negedge clk_i);
        sp_m = 16'h0100; pc_m = 16'h0040; fl_m = 8'h5A;
    endtask

    task automatic t_int(input logic [3:0] vec, input int wn, input bit hold, input string tag);
        int base;
        wait_n = wn; hold_mode = hold;
        base = lcnt;
        pulse(1'b1, 1'b0, vec);
        wait_done({tag, " R3 done"});
        check_push_pair(base, wn + 2, tag);
        sp_m = sp_m - 16'd4; pc_m = 16'(vec) << 3;
        chk(sp_o == sp_m, {tag, " R2 sp"}, 32'(sp_o), 32'(sp_m));
        chk(pc_o == pc_m, {tag, " R3 pc entry"}, 32'(pc_o), 32'(pc_m));
        hold_mode = 1'b0;
    endtask

    task automatic t_ret(input int wn, input string tag);
        int base;
        logic [15:0] epc, efl;
        wait_n = wn;
        epc = mem[sp_m[7:1]];
        efl = mem[(sp_m + 16'd2) >> 1 & 16'h7F];
        base = lcnt;
        pulse(1'b0, 1'b1, 4'd0);
        wait_done({tag, " R4 done"});
        chk(lcnt - base == 2, {tag, " R4 count"}, 32'(lcnt - base), 32'd2);
        chk(log_adr[base % 64] == sp_m && !log_we[base % 64], {tag, " R4 first adr"},
            32'(log_adr[base % 64]), 32'(sp_m));
        chk(log_adr[(base+1) % 64] == sp_m + 16'd2 && !log_we[(base+1) % 64], {tag, " R4 second adr"},
            32'(log_adr[(base+1) % 64]), 32'(sp_m + 16'd2));
        chk(log_sel_ok[base % 64] && log_sel_ok[(base+1) % 64], {tag, " R5 read signals"},
            32'(log_sel_ok[base % 64]), 32'd1);
        chk(log_len[base % 64] == 2, {tag, " R8 two-clock cycle"}, 32'(log_len[base % 64]), 32'd2);
        sp_m = sp_m + 16'd4; pc_m = epc; fl_m = efl[7:0];
        chk(pc_o == pc_m, {tag, " R4 pc"}, 32'(pc_o), 32'(pc_m));
        chk(flags_o == fl_m, {tag, " R4 flags"}, 32'(flags_o), 32'(fl_m));
        chk(sp_o == sp_m, {tag, " R4 sp"}, 32'(sp_o), 32'(sp_m));
    endtask

    task automatic t_both();
        int base;
        wait_n = 0;
        base = lcnt;
        pulse(1'b1, 1'b1, 4'd1);
        wait_done("R10 done");
        chk(log_we[base % 64] && log_we[(base+1) % 64], "R10 interrupt wins",
            32'(log_we[base % 64]), 32'd1);
        check_push_pair(base, 2, "R10");
        sp_m = sp_m - 16'd4; pc_m = 16'h0008;
        chk(pc_o == pc_m && sp_o == sp_m, "R10 regs", {sp_o, pc_o}, {sp_m, pc_m});
    endtask

    task automatic t_busy();
        int base;
        wait_n = 2;
        base = lcnt;
        pulse(1'b1, 1'b0, 4'd3);
        @(negedge clk_i);
        pulse(1'b0, 1'b1, 4'd0);
        wait_done("R9 done");
        repeat (6) @(negedge clk_i);
        chk(lcnt - base == 2 && !stb_o, "R9 no extra transfer", 32'(lcnt - base), 32'd2);
        check_push_pair(base, 4, "R9");
        sp_m = sp_m - 16'd4; pc_m = 16'h0018;
        chk(pc_o == pc_m && sp_o == sp_m, "R9 regs", {sp_o, pc_o}, {sp_m, pc_m});
        chk(flags_o == fl_m, "R9 flags kept", 32'(flags_o), 32'(fl_m));
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        t_reset();
        t_int(4'd5, 0, 1'b0, "R8 int wait0");
        t_ret(0, "R4 roundtrip");
        t_int(4'd15, 3, 1'b0, "R6 int wait3");
        mem[8'hFC >> 1] = 16'h1234;
        mem[8'hFE >> 1] = 16'hABCD;
        t_ret(0, "R4 loaded");
        t_int(4'd2, 1, 1'b1, "R7 stale ack");
        t_both();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule